// File: doc/BRIEF.md
# SPI Register Access Slave

This block is the peripheral end of a serial register port. A host runs one 32-bit full-duplex transfer per access. The block turns each transfer into a read or a write on a plain parallel register bus with 64 entries of 24 bits. The most significant received bit selects the direction. The next six bits name the register, and the low 24 bits carry write data. During a read, the addressed register's contents return on MISO in the low 24 bit slots of that same transfer.

The serial pins are sampled by the system clock through synchronisers, so the serial clock must be several times slower than the system clock. Chip select is active high. The serial clock idles high. Input data is taken on the falling serial clock edge, and output data changes on the rising edge. The register logic behind the block sees a registered address, write data, a one-cycle write strobe, and a combinational read-data return.

Top module: `spi_reg_slave`

## Requirements
- R1: A transfer is 32 bits, most significant bit first. Frame bit 31 set to 1 means write and set to 0 means read.
- R2: Frame bits 30:25 hold the register number. It appears on `reg_addr` once the seventh frame bit (frame bit 25) has been taken in, and it holds until the next frame replaces it.
- R3: In a write frame, `reg_wr` pulses for exactly one system clock after the 32nd bit has been taken in with chip select still high. During the pulse, `reg_wdata` equals frame bits 23:0 and `reg_addr` is the frame's register number.
- R4: Frame bit 24 has no effect on either the address or the data written.
- R5: A read frame never pulses `reg_wr`. Its MISO bits in frame positions 23:0 are the addressed register's value, most significant bit first.
- R6: MISO is 0 in frame positions 31:24, and it is 0 while chip select is low.
- R7: MOSI is taken on falling `spi_sclk` edges (the clock idles high). MISO changes only after rising edges.
- R8: If chip select falls before all 32 bits have arrived, the frame is dropped and no write happens. The next frame starts again at bit 31.
- R9: After reset, `reg_wr`, `spi_miso` and `reg_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | 6 | Register number |
| reg_wdata | output | 24 | Write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 24 | Read data for `reg_addr`, combinational |

## Verification
A wrong bit count or a slipped shift register shows up within one frame. It produces a misplaced address on `reg_addr` after bit 25, a wrong write to a neighbouring register, or a read word shifted by one position on MISO. A missed or extra write strobe changes the host-visible register contents, and the next read of that address exposes it. A frame cut short that still writes is caught by reading the targeted register back in the following frame.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
   typedef enum logic {
      ACC_READ  = 1'b0,
      ACC_WRITE = 1'b1
   } acc_kind_e;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else if (s == 0) stg[s] <= d;
            else stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spireg_rx.sv
module spireg_rx #(
   parameter int FRAME_W = 32,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_s,
   input  logic               fall,
   input  logic               mosi_s,
   output logic [FRAME_W-1:0] shreg,
   output logic [CNT_W-1:0]   bit_cnt
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_cnt <= '0;
      end else if (!cs_s) begin
         bit_cnt <= '0;
      end else if (fall && bit_cnt != FULL) begin
         shreg   <= {shreg[FRAME_W-2:0], mosi_s};
         bit_cnt <= bit_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/spireg_tx.sv
module spireg_tx #(
   parameter int FRAME_W = 32,
   parameter int DATA_W  = 24,
   parameter bit OUT_REG = 1'b1,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              rise,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic              miso
);
   localparam int               PAD_BITS = FRAME_W - DATA_W;
   localparam logic [CNT_W-1:0] PAD_CNT  = CNT_W'(PAD_BITS);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_W);

   logic [CNT_W-1:0]  rise_cnt;
   logic [DATA_W-1:0] out_sr;
   logic              miso_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_cnt <= '0;
         out_sr   <= '0;
      end else begin
         if (!cs_s) rise_cnt <= '0;
         else if (rise && rise_cnt != FULL) rise_cnt <= rise_cnt + 1'b1;

         if (load) out_sr <= load_data;
         else if (cs_s && rise && rise_cnt >= PAD_CNT)
            out_sr <= {out_sr[DATA_W-2:0], 1'b0};
      end
   end

   assign miso_c = cs_s && (rise_cnt >= PAD_CNT) && (rise_cnt != FULL) && out_sr[DATA_W-1];

   generate
      if (OUT_REG) begin : g_oreg
         logic miso_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) miso_q <= 1'b0;
            else miso_q <= miso_c;
         end
         assign miso = miso_q;
      end else begin : g_ocomb
         assign miso = miso_c;
      end
   endgenerate
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
   parameter int FRAME_W     = 32,
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 24,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_wr,
   input  logic [DATA_W-1:0] reg_rdata
);
   import spireg_pkg::*;

   localparam int               CNT_W    = $clog2(FRAME_W + 1);
   localparam int               HDR_BITS = 1 + ADDR_W;
   localparam logic [CNT_W-1:0] HDR_CNT  = CNT_W'(HDR_BITS);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_W);

   initial begin
      assert (FRAME_W >= HDR_BITS + DATA_W)
         else $error("frame too narrow for header and data");
      assert (SYNC_STAGES >= 1) else $error("need at least one sync stage");
      assert (DATA_W >= 2) else $error("data width too small");
   end

   logic [2:0]         pins_s;
   logic               sclk_s, cs_s, mosi_s, sclk_d;
   logic               fall, rise;
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   bit_cnt, cnt_d;
   logic               hdr_evt, done_evt, rd_load;
   acc_kind_e          kind;

   spireg_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n),
      .d({spi_sclk, spi_cs, spi_mosi}), .q(pins_s)
   );
   assign {sclk_s, cs_s, mosi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b1;
         cnt_d  <= '0;
      end else begin
         sclk_d <= sclk_s;
         cnt_d  <= bit_cnt;
      end
   end

   assign fall = cs_s && sclk_d && !sclk_s;
   assign rise = cs_s && !sclk_d && sclk_s;

   spireg_rx #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) rx_i (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .fall(fall),
      .mosi_s(mosi_s), .shreg(shreg), .bit_cnt(bit_cnt)
   );

   assign hdr_evt  = (bit_cnt == HDR_CNT) && (cnt_d != HDR_CNT);
   assign done_evt = (bit_cnt == FULL) && (cnt_d != FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_addr  <= '0;
         reg_wdata <= '0;
         reg_wr    <= 1'b0;
         rd_load   <= 1'b0;
         kind      <= ACC_READ;
      end else begin
         rd_load <= hdr_evt;
         reg_wr  <= done_evt && (kind == ACC_WRITE);
         if (hdr_evt) begin
            reg_addr <= shreg[ADDR_W-1:0];
            kind     <= acc_kind_e'(shreg[ADDR_W]);
         end
         if (done_evt) reg_wdata <= shreg[DATA_W-1:0];
      end
   end

   spireg_tx #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .OUT_REG(OUT_REG), .CNT_W(CNT_W)) tx_i (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rise(rise),
      .load(rd_load), .load_data(reg_rdata), .miso(spi_miso)
   );
endmodule

// File: rtl/spireg_chk.sv
module spireg_chk #(
   parameter int FRAME_W = 32,
   parameter int ADDR_W  = 6,
   parameter int CNT_W   = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              spi_miso,
   input logic              cs_s,
   input logic [CNT_W-1:0]  bit_cnt
);
   // R3
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);
   // R3
   wr_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> $stable(reg_addr));
   // R3
   wr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> $past(bit_cnt) == CNT_W'(FRAME_W));
   // R6
   miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_s && !$past(cs_s)) |-> !spi_miso);
   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_W));
   // R8
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> bit_cnt == '0);
endmodule

bind spi_reg_slave spireg_chk #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .spi_miso(spi_miso), .cs_s(cs_s), .bit_cnt(bit_cnt)
);

// File: tb/spi_reg_slave_tb.sv
`timescale 1ns/1ps
module spi_reg_slave_tb_top;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b1, cs = 1'b0, mosi = 1'b0;
   logic        miso;
   logic [5:0]  reg_addr;
   logic [23:0] reg_wdata, reg_rdata;
   logic        reg_wr;

   logic [23:0] bank   [64];
   logic [23:0] refmem [64];
   int          wr_cnt = 0;
   int          checks = 0, fails = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   spi_reg_slave dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs(cs), .spi_mosi(mosi),
      .spi_miso(miso), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rdata(reg_rdata)
   );

   assign reg_rdata = bank[reg_addr];

   always @(posedge clk) if (rst_n && reg_wr) begin
      bank[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
   end

   function automatic logic [23:0] pattern(input int a, input int pass);
      return 24'((a * 24'h02A5B3) ^ (pass * 24'h5C3001) ^ (a << 18) ^ 24'h00F00F);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic halfp();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic xfer(input logic [31:0] w, input int nbits, output logic [31:0] r);
      r = '0;
      cs = 1'b1; mosi = w[31];
      halfp();
      for (int k = 0; k < nbits; k++) begin
         r[31-k] = miso;
         sclk = 1'b0;
         halfp();
         sclk = 1'b1;
         if (k < 31) mosi = w[30-k];
         halfp();
      end
      cs = 1'b0;
      halfp(); halfp();
   endtask

   function automatic logic [31:0] wframe(input int a, input logic [23:0] d, input bit b24);
      return {1'b1, 6'(a), b24, d};
   endfunction

   function automatic logic [31:0] rframe(input int a, input logic [23:0] junk);
      return {1'b0, 6'(a), 1'b0, junk};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      int          w0;
      for (int i = 0; i < 64; i++) begin bank[i] = '0; refmem[i] = '0; end
      repeat (5) @(negedge clk);
      // R9 reset state
      chk(miso == 1'b0, "R9 miso", 32'(miso), 0);
      chk(reg_wr == 1'b0, "R9 reg_wr", 32'(reg_wr), 0);
      chk(reg_addr == '0, "R9 reg_addr", 32'(reg_addr), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 R3 R4 R7: write every register, bit 24 set on odd addresses
      for (int a = 0; a < 64; a++) begin
         w0 = wr_cnt;
         refmem[a] = pattern(a, 1);
         xfer(wframe(a, refmem[a], a[0]), 32, r);
         chk(wr_cnt == w0 + 1, "R3 one strobe", 32'(wr_cnt - w0), 1);
         chk(bank[a] == refmem[a], "R3 R4 data written", 32'(bank[a]), 32'(refmem[a]));
      end

      // R2 R5 R6 R7: read every register back in descending order
      for (int a = 63; a >= 0; a--) begin
         w0 = wr_cnt;
         xfer(rframe(a, 24'hFFFFFF), 32, r);
         chk(r[23:0] == refmem[a], "R5 R7 read data", 32'(r[23:0]), 32'(refmem[a]));
         chk(r[31:24] == 8'h00, "R6 upper zero", 32'(r[31:24]), 0);
         chk(reg_addr == 6'(a), "R2 address", 32'(reg_addr), 32'(a));
         chk(wr_cnt == w0, "R5 no strobe", 32'(wr_cnt - w0), 0);
         chk(miso == 1'b0, "R6 idle miso", 32'(miso), 0);
      end

      // R8: aborted write frames at several lengths
      for (int n = 7; n < 32; n += 8) begin
         w0 = wr_cnt;
         xfer(wframe(5, ~refmem[5], 1'b0), n, r);
         chk(wr_cnt == w0, "R8 aborted no strobe", 32'(wr_cnt - w0), 0);
      end
      w0 = wr_cnt;
      xfer(wframe(5, 24'h123456, 1'b0), 31, r);
      chk(wr_cnt == w0, "R8 31-bit frame dropped", 32'(wr_cnt - w0), 0);
      xfer(rframe(5, 24'h0), 32, r);
      chk(r[23:0] == refmem[5], "R8 contents kept", 32'(r[23:0]), 32'(refmem[5]));

      // R8 R1: full frame right after an abort is decoded from bit 31
      refmem[9] = pattern(9, 2);
      xfer(wframe(9, refmem[9], 1'b1), 32, r);
      xfer(rframe(9, 24'h0), 32, r);
      chk(r[23:0] == refmem[9], "R8 R1 restart", 32'(r[23:0]), 32'(refmem[9]));

      // R4: bit 24 set on a read frame has no effect on address
      xfer({1'b0, 6'd62, 1'b1, 24'h0}, 32, r);
      chk(r[23:0] == refmem[62], "R4 read bit24", 32'(r[23:0]), 32'(refmem[62]));
      chk(reg_addr == 6'd62, "R4 R2 address", 32'(reg_addr), 62);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule